// File: doc/BRIEF.md
# Cascadable Timer Count-Control Front-End

This block drives a 16-bit up-counter from a byte-wide control register. The register holds an enable bit, a three-bit source selector, a synchronous-restart bit, a cascade bit and a keep-running-in-standby bit. From the selected source the block makes a single-cycle count enable. The source can be every clock, every second clock, a tick from one of two companion timers, or a rising edge on an event input. The counter wraps at full scale and gives a one-cycle overflow pulse, so a second counter can be chained above it.

The counter can be slaved to a companion timer, so that it returns to zero whenever that companion restarts or overflows. A capture input copies the running count into a holding register. In cascade mode the capture is held back by one clock, which lines up a lower and an upper counter whose carry crosses a register stage.

Top module: `tcf_top`

## Requirements
- R1: The control register resets to 0x00. A write stores bit 0 as enable, bits 3:1 as source select, bit 4 as sync-restart, bit 5 as cascade and bit 6 as run-in-standby. Reading returns those seven bits with bit 7 always 0.
- R2: Select 0 advances the counter by one on every clock while enabled.
- R3: Select 1 advances the counter on every second clock. The divider is cleared while disabled, so the first advance comes at the second clock edge after enabling.
- R4: Select 2 advances on companion tick 0 (port bit 0) and select 3 on companion tick 1 (port bit 1). The other companion's tick is ignored.
- R5: Select 7 advances once per rising edge of the event input. A level held high gives only one advance.
- R6: Selects 4, 5 and 6 never advance the counter.
- R7: With enable at 0 the counter neither advances nor captures.
- R8: With sync-restart at 1, the counter loads zero when the selected companion (companion 1 for select 3, otherwise companion 0) restarts or overflows. This load wins over a count in the same cycle, and the other companion's restart and overflow are ignored.
- R9: With sync-restart at 0, companion restart and overflow inputs have no effect.
- R10: A capture pulse stores the count of the same cycle when cascade is 0. When cascade is 1 it stores the count of the following cycle, one clock later.
- R11: While standby is high and run-in-standby is 0, counting and capture are frozen. With run-in-standby at 1, standby has no effect.
- R12: The counter wraps from 0xFFFF to 0x0000. The overflow output is high for exactly the one cycle in which the count reads 0x0000 after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| comp_tick | input | 2 | Count ticks from companion timers 0 and 1 |
| comp_restart | input | 2 | Restart pulses from companion timers 0 and 1 |
| comp_ovf | input | 2 | Overflow pulses from companion timers 0 and 1 |
| evt_in | input | 1 | Event input counted on rising edges |
| capt_in | input | 1 | Capture request |
| standby | input | 1 | Standby sleep indication |
| count | output | 16 | Current counter value |
| capt_val | output | 16 | Last captured count |
| ovf | output | 1 | One-cycle wrap pulse |

## Verification
A register write becomes visible one edge after the strobe. A count, restart or overflow shows on the ports at the first rising edge after its cause. A capture lands at that same edge, or one edge later in cascade mode. The divide-by-two source gives its first advance at the second edge after it is enabled. The bench drives every input and samples every output on the falling edge. Each expected value is then read a whole number of edges after its stimulus, and the edge counts above are used for every check, including the one-edge gap that separates plain capture from cascade capture.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic [2:0] {
    SEL_DIV1 = 3'd0,
    SEL_DIV2 = 3'd1,
    SEL_CMP0 = 3'd2,
    SEL_CMP1 = 3'd3,
    SEL_EVT  = 3'd7
  } sel_e;

  typedef struct packed {
    logic rsv;
    logic run_stby;
    logic casc;
    logic sync_rst;
    sel_e sel;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tcf_ctrl_reg.sv
module tcf_ctrl_reg
  import tcf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output ctrl_t      ctrl
);
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl;
    if (wr) begin
      ctrl_d     = ctrl_t'(wdata);
      ctrl_d.rsv = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= ctrl_t'(8'h00);
    else        ctrl <= ctrl_d;
  end
endmodule

// File: rtl/tcf_tick_gen.sv
module tcf_tick_gen
  import tcf_pkg::*;
#(
  parameter int N_COMP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              run_stby,
  input  logic              sync_rst,
  input  sel_e              sel,
  input  logic              standby,
  input  logic [N_COMP-1:0] comp_tick,
  input  logic [N_COMP-1:0] comp_restart,
  input  logic [N_COMP-1:0] comp_ovf,
  input  logic              evt_in,
  output logic              active,
  output logic              tick,
  output logic              restart
);
  localparam int IDX_W = (N_COMP > 1) ? $clog2(N_COMP) : 1;

  logic             div_q, div_d;
  logic             evt_q;
  logic             raw;
  logic [IDX_W-1:0] cidx;

  always_comb active = en & ~(standby & ~run_stby);

  always_comb begin
    div_d = div_q;
    if (!en)         div_d = 1'b0;
    else if (active) div_d = ~div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      div_q <= div_d;
      evt_q <= evt_in;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DIV1: raw = 1'b1;
      SEL_DIV2: raw = div_q;
      SEL_CMP0: raw = comp_tick[0];
      SEL_CMP1: raw = comp_tick[1];
      SEL_EVT:  raw = evt_in & ~evt_q;
      default:  raw = 1'b0;
    endcase
  end

  always_comb begin
    cidx    = (sel == SEL_CMP1) ? IDX_W'(1) : '0;
    tick    = active & raw;
    restart = active & sync_rst & (comp_restart[cidx] | comp_ovf[cidx]);
  end

  // R3
  div2_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DIV2 && tick) |=> (sel != SEL_DIV2) || !tick);
endmodule

// File: rtl/tcf_counter.sv
module tcf_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             restart,
  input  logic             casc,
  input  logic             capt_in,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capt_val,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d, capt_d;
  logic             ovf_d, capt_q, capt_eff;

  always_comb begin
    capt_eff = casc ? capt_q : capt_in;
    cnt_d    = count;
    if (restart)   cnt_d = '0;
    else if (tick) cnt_d = count + 1'b1;
    ovf_d    = tick & ~restart & (count == CNT_MAX);
    capt_d   = capt_val;
    if (active && capt_eff) capt_d = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      capt_val <= '0;
      ovf      <= 1'b0;
      capt_q   <= 1'b0;
    end else begin
      count    <= cnt_d;
      capt_val <= capt_d;
      ovf      <= ovf_d;
      capt_q   <= capt_in;
    end
  end

  // R12
  ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (count == '0));
  // R8
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (count == '0));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(count) && $stable(capt_val));
endmodule

// File: rtl/tcf_top.sv
module tcf_top
  import tcf_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_COMP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [N_COMP-1:0] comp_tick,
  input  logic [N_COMP-1:0] comp_restart,
  input  logic [N_COMP-1:0] comp_ovf,
  input  logic              evt_in,
  input  logic              capt_in,
  input  logic              standby,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capt_val,
  output logic              ovf
);
  logic  rst_meta, rst_sync_n;
  ctrl_t ctrl;
  logic  active, tick, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tcf_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .ctrl  (ctrl)
  );

  tcf_tick_gen #(.N_COMP(N_COMP)) u_tick (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .en           (ctrl.en),
    .run_stby     (ctrl.run_stby),
    .sync_rst     (ctrl.sync_rst),
    .sel          (ctrl.sel),
    .standby      (standby),
    .comp_tick    (comp_tick),
    .comp_restart (comp_restart),
    .comp_ovf     (comp_ovf),
    .evt_in       (evt_in),
    .active       (active),
    .tick         (tick),
    .restart      (restart)
  );

  tcf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .active   (active),
    .tick     (tick),
    .restart  (restart),
    .casc     (ctrl.casc),
    .capt_in  (capt_in),
    .count    (count),
    .capt_val (capt_val),
    .ovf      (ovf)
  );

  always_comb reg_rdata = ctrl;

  // R1
  readback_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr |=> (reg_rdata == {1'b0, $past(reg_wdata[6:0])}));
  // R6
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl.sel[2] && ctrl.sel != SEL_EVT && !restart) |=> $stable(count));
endmodule

// File: tb/tcf_top_bench.sv
module tcf_top_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [1:0]  comp_tick = 2'b00;
  logic [1:0]  comp_restart = 2'b00;
  logic [1:0]  comp_ovf = 2'b00;
  logic        evt_in = 1'b0;
  logic        capt_in = 1'b0;
  logic        standby = 1'b0;
  logic [15:0] count;
  logic [15:0] capt_val;
  logic        ovf;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcf_top u_tcf_top (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .comp_tick(comp_tick), .comp_restart(comp_restart),
    .comp_ovf(comp_ovf), .evt_in(evt_in), .capt_in(capt_in), .standby(standby),
    .count(count), .capt_val(capt_val), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mk(input bit rs, input bit cas, input bit sy,
                                    input logic [2:0] sel, input bit en);
    return {1'b0, rs, cas, sy, sel, en};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_wr = 1'b0; comp_tick = '0; comp_restart = '0;
    comp_ovf = '0; evt_in = 1'b0; capt_in = 1'b0; standby = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(reg_rdata == 8'h00, "R1 reset rdata", reg_rdata, 8'h00);
    check(count == 16'h0 && capt_val == 16'h0 && ovf == 1'b0, "R1 reset outputs",
          {count, capt_val}, 32'h0);
  endtask

  task automatic t_regs();
    do_reset();
    wr(8'hFF);
    check(reg_rdata == 8'h7F, "R1 bit7 reads 0", reg_rdata, 8'h7F);
    wr(8'h2A);
    check(reg_rdata == 8'h2A, "R1 readback", reg_rdata, 8'h2A);
    wr(8'h00);
  endtask

  task automatic t_div1();
    do_reset();
    wr(mk(0, 0, 0, 3'd0, 1));
    check(count == 16'd0, "R2 start", count, 0);
    repeat (5) @(negedge clk);
    check(count == 16'd5, "R2 every clock", count, 5);
  endtask

  task automatic t_div2();
    do_reset();
    wr(mk(0, 0, 0, 3'd1, 1));
    @(negedge clk);
    check(count == 16'd0, "R3 no tick at first edge", count, 0);
    @(negedge clk);
    check(count == 16'd1, "R3 first tick second edge", count, 1);
    repeat (4) @(negedge clk);
    check(count == 16'd3, "R3 half rate", count, 3);
  endtask

  task automatic t_comp();
    do_reset();
    wr(mk(0, 0, 0, 3'd2, 1));
    comp_tick = 2'b10;
    repeat (3) @(negedge clk);
    check(count == 16'd0, "R4 companion1 ignored on sel2", count, 0);
    comp_tick = 2'b01;
    repeat (3) @(negedge clk);
    comp_tick = 2'b00;
    check(count == 16'd3, "R4 companion0 ticks", count, 3);
    wr(mk(0, 0, 0, 3'd3, 1));
    comp_tick = 2'b01;
    repeat (2) @(negedge clk);
    comp_tick = 2'b10;
    repeat (2) @(negedge clk);
    comp_tick = 2'b00;
    check(count == 16'd5, "R4 companion1 ticks on sel3", count, 5);
  endtask

  task automatic t_event();
    do_reset();
    wr(mk(0, 0, 0, 3'd7, 1));
    evt_in = 1'b1;
    repeat (4) @(negedge clk);
    check(count == 16'd1, "R5 held level counts once", count, 1);
    evt_in = 1'b0; @(negedge clk);
    evt_in = 1'b1; @(negedge clk);
    evt_in = 1'b0; @(negedge clk);
    check(count == 16'd2, "R5 second edge", count, 2);
  endtask

  task automatic t_reserved();
    do_reset();
    for (int s = 4; s <= 6; s++) begin
      wr(mk(0, 0, 0, 3'(s), 1));
      comp_tick = 2'b11;
      for (int k = 0; k < 3; k++) begin
        evt_in = ~evt_in;
        @(negedge clk);
      end
      comp_tick = 2'b00;
      check(count == 16'd0, "R6 reserved select", count, 0);
    end
  endtask

  task automatic t_disable();
    logic [15:0] c;
    do_reset();
    wr(mk(0, 0, 0, 3'd0, 1));
    repeat (3) @(negedge clk);
    wr(mk(0, 0, 0, 3'd0, 0));
    c = count;
    capt_in = 1'b1;
    repeat (3) @(negedge clk);
    capt_in = 1'b0;
    check(count == c, "R7 disabled holds count", count, c);
    check(capt_val == 16'd0, "R7 disabled no capture", capt_val, 0);
  endtask

  task automatic t_restart();
    logic [15:0] c;
    do_reset();
    wr(mk(0, 0, 1, 3'd0, 1));
    repeat (5) @(negedge clk);
    comp_restart = 2'b01; @(negedge clk); comp_restart = 2'b00;
    check(count == 16'd0, "R8 restart beats tick", count, 0);
    @(negedge clk);
    check(count == 16'd1, "R8 counts after restart", count, 1);
    c = count;
    comp_ovf = 2'b10; @(negedge clk); comp_ovf = 2'b00;
    check(count == c + 16'd1, "R8 companion1 ignored on sel0", count, c + 16'd1);
    wr(mk(0, 0, 1, 3'd3, 1));
    c = count;
    comp_restart = 2'b01; @(negedge clk); comp_restart = 2'b00;
    check(count == c, "R8 companion0 ignored on sel3", count, c);
    comp_ovf = 2'b10; @(negedge clk); comp_ovf = 2'b00;
    check(count == 16'd0, "R8 companion1 overflow restarts", count, 0);
    wr(mk(0, 0, 0, 3'd0, 1));
    repeat (2) @(negedge clk);
    c = count;
    comp_restart = 2'b11; comp_ovf = 2'b11;
    @(negedge clk);
    comp_restart = 2'b00; comp_ovf = 2'b00;
    check(count == c + 16'd1, "R9 restart ignored without sync", count, c + 16'd1);
  endtask

  task automatic t_capture();
    logic [15:0] c, p;
    do_reset();
    wr(mk(0, 0, 0, 3'd0, 1));
    repeat (3) @(negedge clk);
    c = count;
    capt_in = 1'b1; @(negedge clk); capt_in = 1'b0;
    check(capt_val == c, "R10 plain capture", capt_val, c);
    wr(mk(0, 1, 0, 3'd0, 1));
    repeat (2) @(negedge clk);
    p = capt_val;
    c = count;
    capt_in = 1'b1; @(negedge clk); capt_in = 1'b0;
    check(capt_val == p, "R10 cascade not yet captured", capt_val, p);
    @(negedge clk);
    check(capt_val == c + 16'd1, "R10 cascade one clock late", capt_val, c + 16'd1);
  endtask

  task automatic t_standby();
    logic [15:0] c;
    do_reset();
    wr(mk(0, 0, 0, 3'd0, 1));
    standby = 1'b1;
    c = count;
    capt_in = 1'b1;
    repeat (4) @(negedge clk);
    capt_in = 1'b0;
    check(count == c, "R11 standby freezes count", count, c);
    check(capt_val == 16'd0, "R11 standby freezes capture", capt_val, 0);
    wr(mk(1, 0, 0, 3'd0, 1));
    c = count;
    repeat (3) @(negedge clk);
    check(count == c + 16'd3, "R11 runs in standby", count, c + 16'd3);
    standby = 1'b0;
  endtask

  task automatic t_wrap();
    do_reset();
    wr(mk(0, 0, 0, 3'd0, 1));
    for (int i = 0; i < 70000 && count != 16'hFFFF; i++) @(negedge clk);
    check(count == 16'hFFFF && ovf == 1'b0, "R12 at full scale", {count, 15'd0, ovf},
          {16'hFFFF, 16'h0});
    @(negedge clk);
    check(count == 16'h0 && ovf == 1'b1, "R12 wrap pulse", {count, 15'd0, ovf},
          32'h1);
    @(negedge clk);
    check(count == 16'h1 && ovf == 1'b0, "R12 pulse one cycle", {count, 15'd0, ovf},
          32'h10000);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_div1();
    t_div2();
    t_comp();
    t_event();
    t_reserved();
    t_disable();
    t_restart();
    t_capture();
    t_standby();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule